// File: doc/BRIEF.md
# Multi-Mode Floating-Point Minimum/Maximum Unit

This unit takes two floating-point operands and a 4-bit mode code and returns one of them: the smaller or the larger, under one of four comparison rules. The rules are the 2008 number-preferring rule, the 2019 NaN-propagating rule, the 2019 number-preferring rule and a plain C-style ternary compare. Each rule also has a magnitude-first form. That form compares absolute values and drops back to the base rule when the magnitudes tie or a NaN is present.

A precision select switches the unit from binary64 operands to binary32 operands held in the low 32 bits of each input. The result is registered and appears with a valid strobe exactly one clock after the operands are accepted. A flag reports a signaling NaN on either input.

Top module: `fp_minmax_unit`

## Requirements
- R1: Mode bit 3 selects maximum when 1 and minimum when 0. Example: minimum of 1.0 and 2.0 is 1.0, maximum is 2.0.
- R2: Mode bit 2 set selects the magnitude form. With unequal magnitudes and no NaN, that form returns the operand with the smaller absolute value for minimum and the larger for maximum, sign kept.
- R3: Mode bits [1:0] = 11 (C-style). Minimum returns A when A < B and otherwise B; maximum returns A when A > B and otherwise B. So a NaN on either side returns B unchanged, and zeros of either sign return B.
- R4: Mode bits [1:0] = 00 (2008 number rule). When exactly one input is NaN, the other input is returned. -0.0 orders below +0.0.
- R5: Mode bits [1:0] = 01 (2019 NaN rule). Any NaN input gives a quiet NaN. -0.0 orders below +0.0.
- R6: Mode bits [1:0] = 10 (2019 number rule). The non-NaN input is returned when exactly one input is NaN. A quiet NaN is returned only when both inputs are NaN.
- R7: In the magnitude form, equal magnitudes or any NaN input give the same result as the base rule selected by bits [1:0].
- R8: Every NaN the unit creates, as opposed to one passed through by the C-style rule, is canonical: 64'h7FF8_0000_0000_0000 in double, or 32'h7FC0_0000 in single.
- R9: snan_flag is 1 with the result when either active operand is a signaling NaN (exponent all ones, mantissa non-zero, mantissa top bit 0), and 0 otherwise.
- R10: With single_sel = 1, only bits [31:0] of each operand are used, the upper 32 bits are ignored, and result[63:32] is 0.
- R11: Non-NaN values order correctly across signs, infinities, zeros and subnormals.
- R12: out_valid is in_valid delayed by one clock. result and snan_flag update only on cycles after in_valid was 1 and hold otherwise.
- R13: A synchronous active-high reset clears out_valid, result and snan_flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and mode are accepted this cycle |
| op_a | input | 64 | Operand A (single: bits [31:0]) |
| op_b | input | 64 | Operand B (single: bits [31:0]) |
| mode | input | 4 | [3] max, [2] magnitude form, [1:0] base rule |
| single_sel | input | 1 | 1 selects binary32 operation |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Selected operand or canonical NaN |
| snan_flag | output | 1 | A signaling NaN was seen on an input |

## Verification
The output register holds the only state, so an error in the select logic appears in result on the cycle after the faulty operands are accepted. A wrong order on signed zeros, or a wrong NaN rule, therefore shows up one clock later as the wrong operand or as a non-canonical NaN. A fault in the valid pipeline or the hold logic shows as out_valid that does not match in_valid delayed by one cycle, or as a result that changes while no operands were accepted. Vectors cover every base rule with mixed zeros and NaNs, and so separate the rules by their results.

// File: rtl/fmm_pkg.sv
package fmm_pkg;
   typedef enum logic [1:0] {
      RULE_NUM08  = 2'b00,
      RULE_NAN19  = 2'b01,
      RULE_NUM19  = 2'b10,
      RULE_CSTYLE = 2'b11
   } base_rule_e;

   typedef struct packed {
      logic       is_max;
      logic       by_mag;
      base_rule_e rule;
   } fmm_mode_t;

   localparam int MODE_W = 4;
endpackage

// File: rtl/fmm_classify.sv
module fmm_classify #(
   parameter int EXP_W = 11,
   parameter int MAN_W = 52,
   localparam int W = 1 + EXP_W + MAN_W
) (
   input  logic [W-1:0]   val,
   output logic           sign,
   output logic [W-2:0]   mag,
   output logic           is_nan,
   output logic           is_snan,
   output logic           is_zero
);
   logic exp_ones, man_nz;
   always_comb begin
      sign     = val[W-1];
      mag      = val[W-2:0];
      exp_ones = &val[W-2:MAN_W];
      man_nz   = |val[MAN_W-1:0];
      is_nan   = exp_ones & man_nz;
      is_snan  = is_nan & ~val[MAN_W-1];
      is_zero  = ~|val[W-2:0];
   end
endmodule

// File: rtl/fmm_pick.sv
module fmm_pick
   import fmm_pkg::*;
#(
   parameter int EXP_W = 11,
   parameter int MAN_W = 52,
   localparam int W = 1 + EXP_W + MAN_W
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  fmm_mode_t    mode,
   output logic [W-1:0] res,
   output logic         snan
);
   localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

   logic           a_s, b_s, a_nan, b_nan, a_sn, b_sn, a_z, b_z;
   logic [W-2:0]   a_m, b_m;

   fmm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_a (
      .val(a), .sign(a_s), .mag(a_m), .is_nan(a_nan), .is_snan(a_sn), .is_zero(a_z));
   fmm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_b (
      .val(b), .sign(b_s), .mag(b_m), .is_nan(b_nan), .is_snan(b_sn), .is_zero(b_z));

   logic any_nan, both_nan, mag_lt, mag_gt;
   logic a_lt_tot, b_lt_tot, a_lt_c, b_lt_c;
   logic take_a, make_nan;

   always_comb begin
      any_nan  = a_nan | b_nan;
      both_nan = a_nan & b_nan;
      mag_lt   = a_m < b_m;
      mag_gt   = a_m > b_m;
      // total order with -0 below +0 (only meaningful without NaN)
      a_lt_tot = (a_s != b_s) ? a_s : (a_s ? mag_gt : mag_lt);
      b_lt_tot = (a_s != b_s) ? b_s : (a_s ? mag_lt : mag_gt);
      // plain comparison: zeros equal, NaN unordered
      a_lt_c   = a_lt_tot & ~(a_z & b_z) & ~any_nan;
      b_lt_c   = b_lt_tot & ~(a_z & b_z) & ~any_nan;

      make_nan = 1'b0;
      take_a   = 1'b0;
      unique case (mode.rule)
         RULE_NUM08, RULE_NUM19: begin
            if (both_nan)   make_nan = 1'b1;
            else if (a_nan) take_a = 1'b0;
            else if (b_nan) take_a = 1'b1;
            else            take_a = mode.is_max ? b_lt_tot : a_lt_tot;
         end
         RULE_NAN19: begin
            if (any_nan) make_nan = 1'b1;
            else         take_a = mode.is_max ? b_lt_tot : a_lt_tot;
         end
         RULE_CSTYLE: take_a = mode.is_max ? b_lt_c : a_lt_c;
         default: take_a = 1'b0;
      endcase

      if (mode.by_mag && !any_nan && (mag_lt || mag_gt)) begin
         make_nan = 1'b0;
         take_a   = mode.is_max ? mag_gt : mag_lt;
      end

      res  = make_nan ? QNAN : (take_a ? a : b);
      snan = a_sn | b_sn;
   end
endmodule

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit
   import fmm_pkg::*;
#(
   parameter int DBL_EXP_W  = 11,
   parameter int DBL_MAN_W  = 52,
   parameter int SGL_EXP_W  = 8,
   parameter int SGL_MAN_W  = 23,
   parameter bit HAS_SINGLE = 1'b1,
   localparam int DW = 1 + DBL_EXP_W + DBL_MAN_W,
   localparam int SW = 1 + SGL_EXP_W + SGL_MAN_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DW-1:0]     op_a,
   input  logic [DW-1:0]     op_b,
   input  logic [MODE_W-1:0] mode,
   input  logic              single_sel,
   output logic              out_valid,
   output logic [DW-1:0]     result,
   output logic              snan_flag
);
   if (SW > DW) begin : g_bad_width
      $error("single format must fit in the double word");
   end
   if (SGL_MAN_W < 2 || DBL_MAN_W < 2 || SGL_EXP_W < 2 || DBL_EXP_W < 2) begin : g_bad_field
      $error("exponent and mantissa fields need at least two bits");
   end

   fmm_mode_t    mode_s;
   logic [DW-1:0] d_res, s_res_ext, nxt_res;
   logic          d_snan, s_snan, nxt_snan;

   assign mode_s = fmm_mode_t'(mode);

   fmm_pick #(.EXP_W(DBL_EXP_W), .MAN_W(DBL_MAN_W)) u_dbl (
      .a(op_a), .b(op_b), .mode(mode_s), .res(d_res), .snan(d_snan));

   if (HAS_SINGLE) begin : g_single
      logic [SW-1:0] s_res;
      fmm_pick #(.EXP_W(SGL_EXP_W), .MAN_W(SGL_MAN_W)) u_sgl (
         .a(op_a[SW-1:0]), .b(op_b[SW-1:0]), .mode(mode_s), .res(s_res), .snan(s_snan));
      assign s_res_ext = {{(DW-SW){1'b0}}, s_res};
   end else begin : g_no_single
      assign s_res_ext = '0;
      assign s_snan    = 1'b0;
   end

   always_comb begin
      if (HAS_SINGLE && single_sel) begin
         nxt_res  = s_res_ext;
         nxt_snan = s_snan;
      end else begin
         nxt_res  = d_res;
         nxt_snan = d_snan;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         result    <= '0;
         snan_flag <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result    <= nxt_res;
            snan_flag <= nxt_snan;
         end
      end
   end
endmodule

// File: rtl/fmm_checker.sv
module fmm_checker #(
   parameter int DW = 64
) (
   input logic          clk,
   input logic          rst,
   input logic          in_valid,
   input logic [DW-1:0] op_a,
   input logic [DW-1:0] op_b,
   input logic [3:0]    mode,
   input logic          single_sel,
   input logic          out_valid,
   input logic [DW-1:0] result,
   input logic          snan_flag
);
   localparam logic [63:0] QN64 = 64'h7FF8_0000_0000_0000;

   logic a_nan, b_nan, a_snan;
   assign a_nan  = (&op_a[62:52]) & (|op_a[51:0]);
   assign b_nan  = (&op_b[62:52]) & (|op_b[51:0]);
   assign a_snan = a_nan & ~op_a[51];

   a_r12_valid_follows: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   a_r12_valid_drops: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   a_r12_hold: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(result) && $stable(snan_flag));
   a_r13_reset_clears: assert property (@(posedge clk)
      rst |=> !out_valid && result == '0 && !snan_flag);
   a_r10_upper_zero: assert property (@(posedge clk) disable iff (rst)
      in_valid && single_sel |=> result[DW-1:32] == '0);
   a_r5_nan_canonical: assert property (@(posedge clk) disable iff (rst)
      in_valid && !single_sel && mode[1:0] == 2'b01 && (a_nan || b_nan) |=> result == QN64);
   a_r4_other_operand: assert property (@(posedge clk) disable iff (rst)
      in_valid && !single_sel && mode[2:0] == 3'b000 && a_nan && !b_nan |=> result == $past(op_b));
   a_r9_snan_seen: assert property (@(posedge clk) disable iff (rst)
      in_valid && !single_sel && a_snan |=> snan_flag);
endmodule

bind fp_minmax_unit fmm_checker #(.DW(DW)) u_fmm_chk (.*);

// File: tb/fp_minmax_unit_test.sv
module fp_minmax_unit_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [63:0] op_a = '0, op_b = '0;
   logic [3:0]  mode = '0;
   logic        single_sel = 1'b0;
   logic        out_valid, snan_flag;
   logic [63:0] result;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   fp_minmax_unit uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .mode(mode), .single_sel(single_sel), .out_valid(out_valid),
      .result(result), .snan_flag(snan_flag));

   localparam logic [63:0] P1 = 64'h3FF0_0000_0000_0000, N1 = 64'hBFF0_0000_0000_0000;
   localparam logic [63:0] P2 = 64'h4000_0000_0000_0000, N2 = 64'hC000_0000_0000_0000;
   localparam logic [63:0] PZ = 64'h0, NZ = 64'h8000_0000_0000_0000;
   localparam logic [63:0] QN = 64'h7FF8_0000_0000_0000, QX = 64'hFFF8_0000_0000_0001;
   localparam logic [63:0] SN = 64'h7FF4_0000_0000_0000, SUB = 64'h1;
   localparam logic [63:0] PI = 64'h7FF0_0000_0000_0000, NI = 64'hFFF0_0000_0000_0000;

   // {req, mode, single, a, b, expected result, expected snan}
   localparam int NV = 31;
   localparam logic [205:0] VEC [NV] = '{
      {8'd1,  4'b0000, 1'b0, P1, P2, P1, 1'b0},            // R1 min
      {8'd1,  4'b1000, 1'b0, P1, P2, P2, 1'b0},            // R1 max
      {8'd11, 4'b0000, 1'b0, N2, P1, N2, 1'b0},            // R11 sign
      {8'd11, 4'b1001, 1'b0, PI, P2, PI, 1'b0},            // R11 infinity
      {8'd11, 4'b0001, 1'b0, SUB, PZ, PZ, 1'b0},           // R11 subnormal
      {8'd11, 4'b0000, 1'b0, NI, N2, NI, 1'b0},            // R11 neg infinity
      {8'd4,  4'b0000, 1'b0, QN, P1, P1, 1'b0},            // R4 a NaN
      {8'd4,  4'b1000, 1'b0, P2, QX, P2, 1'b0},            // R4 b NaN
      {8'd4,  4'b0000, 1'b0, PZ, NZ, NZ, 1'b0},            // R4 -0 < +0
      {8'd4,  4'b1000, 1'b0, NZ, PZ, PZ, 1'b0},            // R4 max zeros
      {8'd5,  4'b0001, 1'b0, P1, QX, QN, 1'b0},            // R5 / R8 canonical
      {8'd5,  4'b1001, 1'b0, NZ, PZ, PZ, 1'b0},            // R5 zeros
      {8'd5,  4'b0001, 1'b0, PZ, NZ, NZ, 1'b0},            // R5 zeros min
      {8'd6,  4'b0010, 1'b0, QX, SN, QN, 1'b1},            // R6 both NaN, R9
      {8'd6,  4'b1010, 1'b0, SN, P1, P1, 1'b1},            // R6 one NaN, R9
      {8'd3,  4'b0011, 1'b0, QN, P1, P1, 1'b0},            // R3 NaN a
      {8'd3,  4'b1011, 1'b0, P1, QX, QX, 1'b0},            // R3 NaN b raw
      {8'd3,  4'b0011, 1'b0, PZ, NZ, NZ, 1'b0},            // R3 zeros -> b
      {8'd3,  4'b0011, 1'b0, NZ, PZ, PZ, 1'b0},            // R3 zeros -> b
      {8'd2,  4'b0100, 1'b0, N2, P1, P1, 1'b0},            // R2 minmag
      {8'd2,  4'b1100, 1'b0, N2, P1, N2, 1'b0},            // R2 maxmag
      {8'd2,  4'b0111, 1'b0, N1, P2, N1, 1'b0},            // R2 C-style form
      {8'd7,  4'b0101, 1'b0, N1, P1, N1, 1'b0},            // R7 tie fallback
      {8'd7,  4'b1101, 1'b0, N1, P1, P1, 1'b0},            // R7 tie fallback max
      {8'd7,  4'b0110, 1'b0, QN, P2, P2, 1'b0},            // R7 NaN fallback
      {8'd7,  4'b0111, 1'b0, P1, N1, N1, 1'b0},            // R7 C-style tie
      {8'd7,  4'b1111, 1'b0, P1, N1, P1, 1'b0},            // R7 C-style tie max
      {8'd10, 4'b0000, 1'b1, 64'hFFFF_FFFF_3F80_0000, 64'h1234_5678_4000_0000,
               64'h0000_0000_3F80_0000, 1'b0},               // R10 min
      {8'd10, 4'b1001, 1'b1, 64'h0000_0000_7FA0_0000, 64'h0000_0000_4000_0000,
               64'h0000_0000_7FC0_0000, 1'b1},               // R10 / R8 / R9
      {8'd10, 4'b1100, 1'b1, 64'h0000_0000_C000_0000, 64'h0000_0000_3F80_0000,
               64'h0000_0000_C000_0000, 1'b0},               // R10 maxmag
      {8'd10, 4'b0000, 1'b1, 64'h7FF4_0000_3F80_0000, 64'h0000_0000_4000_0000,
               64'h0000_0000_3F80_0000, 1'b0}                // R10 upper ignored
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [3:0] m, input logic s, input logic [63:0] a,
                        input logic [63:0] b);
      @(negedge clk);
      mode = m; single_sel = s; op_a = a; op_b = b; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R13 reset out_valid", {63'd0, out_valid}, 64'd0);
      chk("R13 reset result", result, 64'd0);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         logic [205:0] v;
         string tag;
         v = VEC[i];
         issue(v[197:194], v[193], v[192:129], v[128:65]);
         tag = $sformatf("R%0d vector %0d", v[205:198], i);
         chk({tag, " result"}, result, v[64:1]);
         chk({tag, " snan"}, {63'd0, snan_flag}, {63'd0, v[0]});
         chk({tag, " R12 valid"}, {63'd0, out_valid}, 64'd1);
      end

      // R12: idle cycle keeps result, drops valid
      @(negedge clk);
      op_a = P2; op_b = P2; mode = 4'b1000; single_sel = 1'b0;
      @(negedge clk);
      chk("R12 idle valid", {63'd0, out_valid}, 64'd0);
      chk("R12 idle hold", result, 64'h0000_0000_3F80_0000);

      // R13: reset after activity
      issue(4'b1000, 1'b0, SN, P2);
      chk("R9 snan before reset", {63'd0, snan_flag}, 64'd1);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      chk("R13 clear result", result, 64'd0);
      chk("R13 clear snan", {63'd0, snan_flag}, 64'd0);
      chk("R13 clear valid", {63'd0, out_valid}, 64'd0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule